// File: doc/BRIEF.md
# Test Wrapper Output Stage Cell

This cell sits on one output port of a router that is being tested in place. In functional operation it is transparent: the router's output flits, valid strobes and the link's ready strobes pass through it combinationally. In test operation a small control code tells it what to do with the port. It can pull response flits out of the router, or take flits arriving along the wrapper chain from the previous cell. It parks each flit in a per-virtual-channel holding slot and then passes it on, either along the chain to the next cell or out onto the network link. Its other test option forwards traffic from a bypass channel, opened by the matching input stage, straight to the link.

Every connection uses a multi-channel send/accept flow control with one send strobe and one accept strobe per virtual channel. A sender may raise send on channel i only if the receiver raised accept on channel i in the previous cycle. The cell produces the accept strobes toward its two upstream neighbours itself. It honours the accept strobes of its two downstream neighbours, moves at most one flit per cycle per output, and keeps both the payload and the channel number of every flit unchanged.

Top module: `ocell_out_stage`

## Requirements
- R1: After reset every holding slot is empty. With test mode off and all inputs low, net_send, nxt_send, prv_accept and byp_accept are all zero. Entering export mode straight after reset sends nothing until a flit has been captured.
- R2: Normal behaviour applies when test_en is 0, or when test_en is 1 and ctrl_code is 000 or any of 100 to 111. In normal behaviour, in the same cycle, net_data equals rtr_data, net_send equals rtr_send and rtr_accept equals net_accept. prv_accept, byp_accept and nxt_send are held at zero.
- R3: Bypass applies when test_en is 1 and ctrl_code is 011. In bypass, in the same cycle, net_data equals byp_data, net_send equals byp_send and byp_accept equals net_accept. rtr_accept, prv_accept and nxt_send are held at zero.
- R4: Shift (test_en 1, ctrl_code 001) and export (test_en 1, ctrl_code 010) are the capture modes. In a capture mode, cap_src picks the source: 0 means the router, 1 means the previous cell. Only the chosen source receives accept strobes; the other source's accept and byp_accept stay zero.
- R5: A flit sent on channel i by the chosen source is stored in slot i. It leaves on channel i with the same payload at the earliest one cycle later: on nxt_send/nxt_data in shift mode, on net_send/net_data in export mode.
- R6: The cell raises send on channel i of an output only if that output's accept on channel i was high in the previous cycle.
- R7: At most one bit of nxt_send is high in any cycle. At most one bit of net_send is high in any capture-mode cycle.
- R8: An accept on channel i toward the chosen source is high only if slot i can take a flit in the next cycle, because it will be empty or will be drained in that cycle. No flit is ever lost or overwritten.
- R9: When several slots hold flits whose output accepted in the previous cycle, the highest-numbered channel is sent first.
- R10: In normal and bypass behaviour the holding slots neither capture nor drain. Flits held before such a period leave unchanged once a capture mode resumes.
- R11: With the downstream accept held high, one channel sustains one captured flit and one delivered flit per cycle without any pause in its accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | 1 selects test behaviour, 0 forces normal behaviour |
| ctrl_code | input | 3 | Test action code (000 normal, 001 shift, 010 export, 011 bypass, others normal) |
| cap_src | input | 1 | Capture source: 0 router, 1 previous cell |
| rtr_data | input | DATA_W | Flit payload from the router output |
| rtr_send | input | NUM_VC | Per-channel send strobes from the router |
| rtr_accept | output | NUM_VC | Per-channel accept strobes to the router |
| prv_data | input | DATA_W | Flit payload from the previous cell |
| prv_send | input | NUM_VC | Per-channel send strobes from the previous cell |
| prv_accept | output | NUM_VC | Per-channel accept strobes to the previous cell |
| byp_data | input | DATA_W | Flit payload on the bypass channel |
| byp_send | input | NUM_VC | Per-channel send strobes on the bypass channel |
| byp_accept | output | NUM_VC | Per-channel accept strobes on the bypass channel |
| net_data | output | DATA_W | Flit payload to the network link |
| net_send | output | NUM_VC | Per-channel send strobes to the network link |
| net_accept | input | NUM_VC | Per-channel accept strobes from the network link |
| nxt_data | output | DATA_W | Flit payload to the next cell |
| nxt_send | output | NUM_VC | Per-channel send strobes to the next cell |
| nxt_accept | input | NUM_VC | Per-channel accept strobes from the next cell |

## Verification
The bench builds the cell with NUM_VC = 3 and DATA_W = 16, one channel more than the default. With three channels, the drain order has a middle priority level, so a wrong priority direction or a one-off index shows up in the delivered sequence and is not hidden by a two-way swap. Three slots held at once across a normal-mode interval show both the freeze and the ordered release. A sixteen-bit payload keeps random data distinct enough to catch a slot or mux mix-up.

// File: rtl/ocell_pkg.sv
// Shared definitions for the wrapper output stage cell.
// Holds the action code values and the decoded routing record.
package ocell_pkg;

    // Action codes carried on ctrl_code; unlisted values act as normal.
    typedef enum logic [2:0] {
        OP_NORMAL = 3'b000,
        OP_SHIFT  = 3'b001,
        OP_EXPORT = 3'b010,
        OP_BYPASS = 3'b011
    } op_e;

    // Decoded routing for one cycle.
    typedef struct packed {
        logic pass_rtr;   // router output drives the link directly
        logic pass_byp;   // bypass channel drives the link directly
        logic capture;    // holding slots capture and drain
        logic to_next;    // drained flits go to the next cell, else to the link
    } route_t;

endpackage

// File: rtl/ocell_mode_dec.sv
// Mode decoder: turns test_en and the action code into a routing record.
// Assumes the code is only changed while no flit is in flight at the cell edge.
module ocell_mode_dec
    import ocell_pkg::*;
(
    input  logic         test_en,
    input  logic [2:0]   code,
    output route_t       route
);

    // Decode the action; anything not recognised falls back to pass-through.
    always_comb begin
        route = '0;
        if (!test_en) begin
            route.pass_rtr = 1'b1;
        end else begin
            case (code)
                OP_SHIFT: begin
                    route.capture = 1'b1;
                    route.to_next = 1'b1;
                end
                OP_EXPORT: begin
                    route.capture = 1'b1;
                end
                OP_BYPASS: begin
                    route.pass_byp = 1'b1;
                end
                default: begin
                    route.pass_rtr = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ocell_vc_arb.sv
// Fixed-priority picker: grants the highest-numbered requesting channel.
// Output is one-hot or zero; purely combinational.
module ocell_vc_arb #(
    parameter int NUM_VC = 2
) (
    input  logic [NUM_VC-1:0] req,
    output logic [NUM_VC-1:0] gnt
);

    // Scan upward so a higher requester overrides a lower one.
    always_comb begin
        gnt = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ocell_hold_bank.sv
// Holding bank: one single-flit slot per virtual channel.
// Assumes capture on a channel only arrives when its slot is free or draining;
// capture takes precedence over drain in the same cycle.
module ocell_hold_bank #(
    parameter int NUM_VC = 2,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_VC-1:0]              cap_vec,
    input  logic [DATA_W-1:0]              cap_data,
    input  logic [NUM_VC-1:0]              drain_vec,
    output logic [NUM_VC-1:0]              hold_v,
    output logic [NUM_VC-1:0][DATA_W-1:0]  hold_d
);

    for (genvar g = 0; g < NUM_VC; g++) begin : g_slot
        // Track occupancy of this channel's slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_v[g] <= 1'b0;
            end else if (cap_vec[g]) begin
                hold_v[g] <= 1'b1;
            end else if (drain_vec[g]) begin
                hold_v[g] <= 1'b0;
            end
        end

        // Load the payload when this channel captures.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_d[g] <= '0;
            end else if (cap_vec[g]) begin
                hold_d[g] <= cap_data;
            end
        end
    end

endmodule

// File: rtl/ocell_out_stage.sv
// Wrapper output stage cell (top).
// Passes router output to the link in normal behaviour, forwards the bypass
// channel in bypass, and in shift/export captures flits from the router or
// the previous cell into per-channel slots, draining them to the next cell or
// the link under per-channel send/accept flow control.
// Assumes each sender raises at most one send bit per cycle and obeys the
// previous-cycle accept rule, and that mode inputs change only while idle.
module ocell_out_stage
    import ocell_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_VC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_en,
    input  logic [2:0]           ctrl_code,
    input  logic                 cap_src,
    input  logic [DATA_W-1:0]    rtr_data,
    input  logic [NUM_VC-1:0]    rtr_send,
    output logic [NUM_VC-1:0]    rtr_accept,
    input  logic [DATA_W-1:0]    prv_data,
    input  logic [NUM_VC-1:0]    prv_send,
    output logic [NUM_VC-1:0]    prv_accept,
    input  logic [DATA_W-1:0]    byp_data,
    input  logic [NUM_VC-1:0]    byp_send,
    output logic [NUM_VC-1:0]    byp_accept,
    output logic [DATA_W-1:0]    net_data,
    output logic [NUM_VC-1:0]    net_send,
    input  logic [NUM_VC-1:0]    net_accept,
    output logic [DATA_W-1:0]    nxt_data,
    output logic [NUM_VC-1:0]    nxt_send,
    input  logic [NUM_VC-1:0]    nxt_accept
);

    localparam int VC_W = NUM_VC;

    route_t                          route;
    logic [VC_W-1:0]                 net_acc_q;
    logic [VC_W-1:0]                 nxt_acc_q;
    logic [VC_W-1:0]                 dest_acc_q;
    logic [VC_W-1:0]                 dest_acc_now;
    logic [VC_W-1:0]                 src_send;
    logic [DATA_W-1:0]               src_data;
    logic [VC_W-1:0]                 cap_vec;
    logic [VC_W-1:0]                 drain_req;
    logic [VC_W-1:0]                 drain_vec;
    logic [VC_W-1:0]                 hold_v;
    logic [VC_W-1:0][DATA_W-1:0]     hold_d;
    logic [VC_W-1:0]                 hv_next;
    logic [VC_W-1:0]                 look_gnt;
    logic [VC_W-1:0]                 src_acc;
    logic [DATA_W-1:0]               out_data;

    ocell_mode_dec u_dec (
        .test_en (test_en),
        .code    (ctrl_code),
        .route   (route)
    );

    // Remember last cycle's downstream accepts; they license this cycle's sends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            net_acc_q <= '0;
            nxt_acc_q <= '0;
        end else begin
            net_acc_q <= net_accept;
            nxt_acc_q <= nxt_accept;
        end
    end

    // Select the active destination's accepts and the chosen capture source.
    always_comb begin
        dest_acc_q   = route.to_next ? nxt_acc_q  : net_acc_q;
        dest_acc_now = route.to_next ? nxt_accept : net_accept;
        src_send     = cap_src ? prv_send : rtr_send;
        src_data     = cap_src ? prv_data : rtr_data;
        cap_vec      = route.capture ? src_send : '0;
        drain_req    = route.capture ? (hold_v & dest_acc_q) : '0;
    end

    ocell_vc_arb #(.NUM_VC(NUM_VC)) u_drain_arb (
        .req (drain_req),
        .gnt (drain_vec)
    );

    ocell_hold_bank #(.NUM_VC(NUM_VC), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_vec   (cap_vec),
        .cap_data  (src_data),
        .drain_vec (drain_vec),
        .hold_v    (hold_v),
        .hold_d    (hold_d)
    );

    // Occupancy the slots will have next cycle.
    always_comb begin
        hv_next = (hold_v & ~drain_vec) | cap_vec;
    end

    // Predict next cycle's drain winner so a full slot that will empty can still accept.
    ocell_vc_arb #(.NUM_VC(NUM_VC)) u_look_arb (
        .req (hv_next & dest_acc_now),
        .gnt (look_gnt)
    );

    // Accept toward the source: slot free next cycle, or the one drained then.
    always_comb begin
        src_acc = route.capture ? (~hv_next | look_gnt) : '0;
    end

    // Pick the payload of the slot being drained.
    always_comb begin
        out_data = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            if (drain_vec[i]) begin
                out_data = hold_d[i];
            end
        end
    end

    // Steer the link output among router, bypass and drained flits.
    always_comb begin
        if (route.pass_byp) begin
            net_data = byp_data;
            net_send = byp_send;
        end else if (route.pass_rtr) begin
            net_data = rtr_data;
            net_send = rtr_send;
        end else begin
            net_data = out_data;
            net_send = route.to_next ? '0 : drain_vec;
        end
    end

    // Drive the chain output; only shift mode sends to the next cell.
    always_comb begin
        nxt_data = out_data;
        nxt_send = (route.capture && route.to_next) ? drain_vec : '0;
    end

    // Route accept strobes back to whichever upstream feeds the cell.
    always_comb begin
        rtr_accept = '0;
        prv_accept = '0;
        byp_accept = '0;
        if (route.pass_rtr) begin
            rtr_accept = net_accept;
        end else if (route.pass_byp) begin
            byp_accept = net_accept;
        end else if (cap_src) begin
            prv_accept = src_acc;
        end else begin
            rtr_accept = src_acc;
        end
    end

endmodule

// File: rtl/ocell_out_stage_chk.sv
// Property checker for the output stage cell, attached with bind below.
// Observes ports plus the slot occupancy and drain grant of the top.
module ocell_out_stage_chk #(
    parameter int NUM_VC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_en,
    input logic [2:0]        ctrl_code,
    input logic              cap_src,
    input logic [NUM_VC-1:0] rtr_accept,
    input logic [NUM_VC-1:0] prv_accept,
    input logic [NUM_VC-1:0] byp_accept,
    input logic [NUM_VC-1:0] net_send,
    input logic [NUM_VC-1:0] net_accept,
    input logic [NUM_VC-1:0] nxt_send,
    input logic [NUM_VC-1:0] nxt_accept,
    input logic [NUM_VC-1:0] hold_v,
    input logic [NUM_VC-1:0] drain_vec
);

    logic cap_mode;
    logic exp_mode;
    logic byp_mode;
    logic nrm_mode;

    assign cap_mode = test_en && (ctrl_code == 3'b001 || ctrl_code == 3'b010);
    assign exp_mode = test_en && (ctrl_code == 3'b010);
    assign byp_mode = test_en && (ctrl_code == 3'b011);
    assign nrm_mode = !cap_mode && !byp_mode;

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (hold_v == '0 && nxt_send == '0));

    p_normal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nrm_mode |-> (prv_accept == '0 && byp_accept == '0 && nxt_send == '0));

    p_bypass_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byp_mode |-> (rtr_accept == '0 && prv_accept == '0 && nxt_send == '0));

    p_src_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode |-> (byp_accept == '0 && (cap_src ? (rtr_accept == '0) : (prv_accept == '0))));

    p_nxt_licensed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_send != '0) |-> ((nxt_send & ~$past(nxt_accept)) == '0));

    p_net_licensed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_mode && $past(exp_mode)) |-> ((net_send & ~$past(net_accept)) == '0));

    p_net_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode |-> $onehot0(net_send));

    p_nxt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nxt_send));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && ((rtr_accept | prv_accept) != '0)) |=>
        (!cap_mode || (($past(rtr_accept | prv_accept) & hold_v & ~drain_vec) == '0)));

    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_mode |=> (hold_v == $past(hold_v)));

endmodule

bind ocell_out_stage ocell_out_stage_chk #(.NUM_VC(NUM_VC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .ctrl_code  (ctrl_code),
    .cap_src    (cap_src),
    .rtr_accept (rtr_accept),
    .prv_accept (prv_accept),
    .byp_accept (byp_accept),
    .net_send   (net_send),
    .net_accept (net_accept),
    .nxt_send   (nxt_send),
    .nxt_accept (nxt_accept),
    .hold_v     (hold_v),
    .drain_vec  (drain_vec)
);

// File: tb/ocell_out_stage_test.sv
`timescale 1ns/1ps
module ocell_out_stage_test;

    localparam int DW = 16;
    localparam int K  = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          test_en;
    logic [2:0]    ctrl_code;
    logic          cap_src;
    logic [DW-1:0] rtr_data, prv_data, byp_data, net_data, nxt_data;
    logic [K-1:0]  rtr_send, rtr_accept, prv_send, prv_accept, byp_send, byp_accept;
    logic [K-1:0]  net_send, net_accept, nxt_send, nxt_accept;

    always #2.5 clk = ~clk;

    ocell_out_stage #(.DATA_W(DW), .NUM_VC(K)) uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .ctrl_code(ctrl_code), .cap_src(cap_src),
        .rtr_data(rtr_data), .rtr_send(rtr_send), .rtr_accept(rtr_accept),
        .prv_data(prv_data), .prv_send(prv_send), .prv_accept(prv_accept),
        .byp_data(byp_data), .byp_send(byp_send), .byp_accept(byp_accept),
        .net_data(net_data), .net_send(net_send), .net_accept(net_accept),
        .nxt_data(nxt_data), .nxt_send(nxt_send), .nxt_accept(nxt_accept)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Stimulus knobs.
    bit         g_en;
    logic [2:0] g_code;
    bit         g_src;
    int         g_pct;
    int         g_acc;
    int         g_force = -1;
    logic [DW-1:0] g_fdata;
    bit         g_rand_normal = 0;

    // Behavioural reference: a one-deep queue per channel.
    logic [DW-1:0] mq [K][$];
    logic [K-1:0]  m_net_q = '0, m_nxt_q = '0;

    // What the bench saw at the ports last cycle.
    logic [K-1:0]  seen_rtr = '0, seen_prv = '0, seen_byp = '0;
    logic [K-1:0]  last_net_acc = '0, last_nxt_acc = '0;
    logic [K-1:0]  obs_net_send, obs_nxt_send, obs_rtr_acc, obs_prv_acc, obs_byp_acc;
    logic [DW-1:0] obs_net_data;
    int            prv_sent_vc1 = 0;
    int            nxt_got_vc1  = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [K-1:0] pick(input logic [K-1:0] seen, input int pct, input int fvc);
        logic [K-1:0] s;
        int v;
        s = '0;
        if (fvc >= 0) begin
            if (seen[fvc]) s[fvc] = 1'b1;
        end else begin
            v = int'($urandom % K);
            if (seen[v] && int'($urandom % 100) < pct) s[v] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [K-1:0] rnd_vec(input int pct);
        logic [K-1:0] s;
        for (int i = 0; i < K; i++) s[i] = (int'($urandom % 100) < pct);
        return s;
    endfunction

    function automatic logic [K-1:0] top_pick(input logic [K-1:0] r);
        logic [K-1:0] g;
        g = '0;
        for (int i = 0; i < K; i++) if (r[i]) begin g = '0; g[i] = 1'b1; end
        return g;
    endfunction

    // One clock: drive at the falling edge, compare 1 ns later, advance the model.
    task automatic tick();
        logic [K-1:0] occ, g, dq, dnow, ssel, hvn, lg, acc;
        logic [K-1:0] e_net_s, e_nxt_s, e_rtr_a, e_prv_a, e_byp_a;
        logic [DW-1:0] sdat, e_data;
        bit capm, bypm, tonext;
        string tg;
        @(negedge clk);
        test_en   = g_en;
        ctrl_code = g_code;
        if (g_rand_normal) begin
            test_en   = $urandom % 2;
            ctrl_code = test_en ? (3'd4 + 3'($urandom % 4)) : 3'($urandom % 8);
            if (test_en && ($urandom % 3) == 0) ctrl_code = 3'd0;
        end
        cap_src    = g_src;
        rtr_send   = pick(seen_rtr, g_pct, g_force);
        prv_send   = pick(seen_prv, g_pct, g_force);
        byp_send   = pick(seen_byp, g_pct, -1);
        rtr_data   = (g_force >= 0) ? g_fdata : DW'($urandom);
        prv_data   = (g_force >= 0) ? g_fdata : DW'($urandom);
        byp_data   = DW'($urandom);
        net_accept = rnd_vec(g_acc);
        nxt_accept = rnd_vec(g_acc);
        #1;
        capm   = test_en && (ctrl_code == 3'd1 || ctrl_code == 3'd2);
        bypm   = test_en && (ctrl_code == 3'd3);
        tonext = (ctrl_code == 3'd1);
        for (int i = 0; i < K; i++) occ[i] = (mq[i].size() != 0);
        e_data = '0;
        g = '0;
        ssel = cap_src ? prv_send : rtr_send;
        sdat = cap_src ? prv_data : rtr_data;
        e_rtr_a = '0; e_prv_a = '0; e_byp_a = '0; e_nxt_s = '0;
        if (capm) begin
            tg   = "R5";
            dq   = tonext ? m_nxt_q : m_net_q;
            g    = top_pick(occ & dq);
            for (int i = 0; i < K; i++) if (g[i]) e_data = mq[i][0];
            hvn  = (occ & ~g) | ssel;
            dnow = tonext ? nxt_accept : net_accept;
            lg   = top_pick(hvn & dnow);
            acc  = ~hvn | lg;
            e_net_s = tonext ? '0 : g;
            e_nxt_s = tonext ? g : '0;
            if (cap_src) e_prv_a = acc; else e_rtr_a = acc;
            chk("R8", "source accept", cap_src ? prv_accept : rtr_accept, acc);
            chk("R4", "unselected accepts", {cap_src ? rtr_accept : prv_accept, byp_accept}, '0);
            if (g != '0) chk("R5", "drained payload", tonext ? nxt_data : net_data, e_data);
        end else if (bypm) begin
            tg = "R3";
            e_net_s = byp_send; e_byp_a = net_accept;
            if (byp_send != '0) chk("R3", "bypass payload", net_data, byp_data);
        end else begin
            tg = "R2";
            e_net_s = rtr_send; e_rtr_a = net_accept;
            if (rtr_send != '0) chk("R2", "pass payload", net_data, rtr_data);
        end
        chk(tg, "net_send", net_send, e_net_s);
        chk(tg, "nxt_send", nxt_send, e_nxt_s);
        chk(tg, "accepts", {rtr_accept, prv_accept, byp_accept}, {e_rtr_a, e_prv_a, e_byp_a});
        chk("R6", "nxt send licensed", nxt_send & ~last_nxt_acc, '0);
        if (capm && !tonext) chk("R6", "net send licensed", net_send & ~last_net_acc, '0);
        chk("R7", "single send", ($countones(nxt_send) <= 1 && (!capm || $countones(net_send) <= 1)), 1);
        // Advance the reference.
        if (capm) begin
            for (int i = 0; i < K; i++) begin
                if (g[i]) void'(mq[i].pop_front());
                if (ssel[i]) mq[i].push_back(sdat);
            end
            for (int i = 0; i < K; i++) chk("R8", "slot depth", mq[i].size() <= 1, 1);
        end
        m_net_q = net_accept;
        m_nxt_q = nxt_accept;
        last_net_acc = net_accept;
        last_nxt_acc = nxt_accept;
        seen_rtr = rtr_accept; seen_prv = prv_accept; seen_byp = byp_accept;
        obs_net_send = net_send; obs_nxt_send = nxt_send; obs_net_data = net_data;
        obs_rtr_acc = rtr_accept; obs_prv_acc = prv_accept; obs_byp_acc = byp_accept;
        if (prv_send[1]) prv_sent_vc1++;
        if (nxt_send[1]) nxt_got_vc1++;
    endtask

    task automatic set_mode(input bit en, input logic [2:0] code, input bit src, input int acc);
        g_en = en; g_code = code; g_src = src; g_acc = acc;
    endtask

    // Quiet edges around a random run so no flit straddles a mode change.
    task automatic phase(input bit en, input logic [2:0] code, input bit src, input int n, input int acc);
        set_mode(en, code, src, acc);
        g_pct = 0; repeat (2) tick();
        g_pct = 60; repeat (n) tick();
        g_pct = 0; repeat (2) tick();
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_up();
        end
    end

    initial begin
        rst_n = 1'b0; test_en = 1'b0; ctrl_code = '0; cap_src = 1'b0;
        rtr_data = '0; prv_data = '0; byp_data = '0;
        rtr_send = '0; prv_send = '0; byp_send = '0; net_accept = '0; nxt_accept = '0;
        g_pct = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: quiet after reset, nothing stale in the slots.
        set_mode(0, 3'd0, 0, 0);
        tick();
        chk("R1", "sends after reset", {obs_net_send, obs_nxt_send}, '0);
        chk("R1", "accepts after reset", {obs_prv_acc, obs_byp_acc}, '0);
        set_mode(1, 3'd2, 0, 100);
        tick(); tick();
        chk("R1", "export sends nothing when empty", obs_net_send, '0);

        // Random runs in every mode and source.
        g_rand_normal = 1;
        phase(0, 3'd0, 0, 40, 60);
        g_rand_normal = 0;
        phase(1, 3'd3, 0, 40, 60);
        phase(1, 3'd1, 0, 60, 50);
        phase(1, 3'd1, 1, 60, 50);
        phase(1, 3'd2, 0, 60, 50);
        phase(1, 3'd2, 1, 60, 50);
        phase(1, 3'd1, 1, 40, 90);

        // R9/R10: fill three slots, freeze through normal mode, release in order.
        set_mode(1, 3'd2, 0, 0);
        g_pct = 0; repeat (4) tick();
        g_force = 0; g_fdata = 16'hA000; tick();
        g_force = 1; g_fdata = 16'hB111; tick();
        g_force = 2; g_fdata = 16'hC222; tick();
        g_force = -1; tick();
        chk("R8", "all slots full, no accept", obs_rtr_acc, '0);
        set_mode(0, 3'd0, 0, 100);
        for (int c = 0; c < 3; c++) begin
            tick();
            chk("R10", "no release in normal mode", obs_nxt_send, '0);
        end
        set_mode(1, 3'd2, 0, 100);
        tick();
        chk("R9", "first release channel 2", obs_net_send, 3'b100);
        chk("R10", "held payload channel 2", obs_net_data, 16'hC222);
        tick();
        chk("R9", "second release channel 1", obs_net_send, 3'b010);
        chk("R10", "held payload channel 1", obs_net_data, 16'hB111);
        tick();
        chk("R9", "third release channel 0", obs_net_send, 3'b001);
        chk("R10", "held payload channel 0", obs_net_data, 16'hA000);
        tick();
        chk("R9", "nothing left", obs_net_send, '0);

        // R11: back-to-back flow on one channel through the chain.
        set_mode(1, 3'd1, 1, 100);
        g_pct = 0; repeat (2) tick();
        prv_sent_vc1 = 0; nxt_got_vc1 = 0;
        g_force = 1;
        for (int c = 0; c < 20; c++) begin
            g_fdata = DW'(16'h5000 + c);
            tick();
        end
        g_force = -1;
        repeat (3) tick();
        chk("R11", "flits accepted without pause", prv_sent_vc1, 20);
        chk("R11", "flits delivered", nxt_got_vc1, 20);

        done = 1;
        finish_up();
    end

endmodule